// File: doc/BRIEF.md
# EEPROM Write-Protection and Status Controller

This block is the back end behind a serial front end for an 8192-byte non-volatile byte memory. The front end decodes each serial instruction and hands it over as one command beat on a valid/ready stream: an operation code, a 13-bit address and a data byte. The block owns the status byte. It gates every modifying operation with a write-enable latch, two region-protect bits and a status-lock bit that the write-protect pin can enforce. It collects up to one 32-byte page of write data. When a write is allowed, it runs a self-timed busy window. During that window the gathered bytes are committed into a behavioural array.

Reads come back on a one-entry valid/ready output stream. While a read result waits for `rd_ready`, `cmd_ready` is low, so the front end cannot issue a second read and overwrite it. While the busy window runs, `cmd_ready` stays high: every beat is taken and dropped, except that the status byte stays visible on `status_o` at all times. Status reads therefore never stall. The busy window lasts `CYCLE_CLKS` clocks, which must be at least the page size. The default stands for a few milliseconds, and the bench shortens it.

Top module: `wp_eeprom_ctrl`

## Requirements
- R1: `status_o` is {lock bit, 3'b000, protect[1:0], enable latch, busy} (bit 7 down to bit 0). Reset clears the busy bit and the enable latch. Reset leaves the lock bit and the protect bits at their stored values.
- R2: Op 1 sets the enable latch and op 2 clears it.
- R3: Op 3 with the latch set loads the lock bit from data bit 7 and the protect bits from data bits 3:2, then clears the latch. With the latch clear it changes nothing.
- R4: Op 3 is rejected, with no status bit changing, while the lock bit is 1 and `wp_n` is low.
- R5: Op 4 sets the page from address bits 12:5 and the byte slot from bits 4:0. Each op 5 stores its data in the current slot and advances the slot modulo 32, so bytes past 32 overwrite earlier slots.
- R6: Op 6 with the latch set, an unprotected page and at least one loaded slot clears the latch and raises busy in the next cycle. Busy then stays high for exactly `CYCLE_CLKS` cycles. After that the loaded bytes read back at their addresses.
- R7: Op 6 with the latch clear starts no busy window and changes no status bit.
- R8: The protect bits guard these regions: 00 guards nothing, 01 guards 0x1800-0x1FFF, 10 guards 0x1000-0x1FFF and 11 guards the whole array. Op 6 on a guarded page still clears the latch, but it starts no window and leaves the array unchanged.
- R9: While busy, every command beat is accepted and ignored. The status bits other than busy stay unchanged and no read result appears.
- R10: Op 7 presents `rd_valid` with the byte at the address in the next cycle. The result holds steady until `rd_ready`, and `cmd_ready` stays low until it is taken. Op 0 has no effect, because the status is always on `status_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Write-protect pin, low enforces the status lock |
| cmd_valid | input | 1 | Command beat valid |
| cmd_ready | output | 1 | Command beat accepted when high with valid |
| cmd_op | input | 3 | Operation code (see R2-R10) |
| cmd_addr | input | 13 | Byte address |
| cmd_data | input | 8 | Data byte |
| status_o | output | 8 | Status byte |
| busy_o | output | 1 | Internal write window active |
| rd_valid | output | 1 | Read result valid |
| rd_ready | input | 1 | Read result taken when high with valid |
| rd_data | output | 8 | Read result byte |

## Verification
Page writes are tried in three patterns: a short run in the middle of a page, a run of 34 bytes that wraps past the page end, and single bytes at each side of every protect boundary. The short run shows the address mapping and the busy length. The wrap shows slot arithmetic and overwrite order. The boundary writes separate the three guarded regions from one another. Status writes are tried with the latch clear, with the latch set and the pin high, and with the lock bit set and the pin low, which separates the two gates. A read held under back-pressure checks that the result is held and that commands stall.

// File: rtl/wp_pkg.sv
`timescale 1ns/1ps
package wp_pkg;
  typedef enum logic [2:0] {
    OP_RDSR   = 3'd0,
    OP_WREN   = 3'd1,
    OP_WRDI   = 3'd2,
    OP_WRSR   = 3'd3,
    OP_LDADDR = 3'd4,
    OP_LDDATA = 3'd5,
    OP_COMMIT = 3'd6,
    OP_READ   = 3'd7
  } wp_op_e;
endpackage

// File: rtl/wp_status_reg.sv
`timescale 1ns/1ps
module wp_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_wel,
  input  logic       clr_wel,
  input  logic       sr_load,
  input  logic       sr_lock,
  input  logic [1:0] sr_prot,
  output logic       wel,
  output logic       lock,
  output logic [1:0] prot
);
  // Non-volatile bits: held across reset, only a status write moves them.
  logic [1:0] prot_q = 2'b00;
  logic       lock_q = 1'b0;
  logic       wel_q;

  always_ff @(posedge clk) begin
    if (sr_load) begin
      prot_q <= sr_prot;
      lock_q <= sr_lock;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wel_q <= 1'b0;
    else if (set_wel) wel_q <= 1'b1;
    else if (clr_wel) wel_q <= 1'b0;
  end

  assign wel  = wel_q;
  assign lock = lock_q;
  assign prot = prot_q;
endmodule

// File: rtl/wp_region.sv
`timescale 1ns/1ps
module wp_region (
  input  logic [1:0] prot,
  input  logic [1:0] top_bits,  // two most significant address bits of the page
  output logic       locked
);
  always_comb begin
    unique case (prot)
      2'b00:   locked = 1'b0;
      2'b01:   locked = &top_bits;
      2'b10:   locked = top_bits[1];
      default: locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/wp_page_buf.sv
`timescale 1ns/1ps
module wp_page_buf #(
  parameter int ADDR_W = 13,
  parameter int PAGE   = 32,
  localparam int OFF_W = $clog2(PAGE),
  localparam int BASE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_addr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              push,
  input  logic [7:0]        push_data,
  input  logic              clear,
  input  logic [OFF_W-1:0]  slot_sel,
  output logic [BASE_W-1:0] page_base,
  output logic              any_used,
  output logic [7:0]        slot_data,
  output logic              slot_used
);
  logic [BASE_W-1:0] base_q;
  logic [OFF_W-1:0]  off_q;
  logic [PAGE-1:0]   used_q;
  logic [7:0]        data_q [PAGE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      off_q  <= '0;
      used_q <= '0;
    end else if (load_addr) begin
      base_q <= addr_in[ADDR_W-1:OFF_W];
      off_q  <= addr_in[OFF_W-1:0];
      used_q <= '0;
    end else if (clear) begin
      used_q <= '0;
    end else if (push) begin
      used_q[off_q] <= 1'b1;
      off_q         <= off_q + 1'b1;  // wraps inside the page
    end
  end

  always_ff @(posedge clk) begin
    if (push && !load_addr && !clear) data_q[off_q] <= push_data;
  end

  assign page_base = base_q;
  assign any_used  = |used_q;
  assign slot_data = data_q[slot_sel];
  assign slot_used = used_q[slot_sel];
endmodule

// File: rtl/wp_eeprom_ctrl.sv
`timescale 1ns/1ps
module wp_eeprom_ctrl
  import wp_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int PAGE       = 32,
  parameter int CYCLE_CLKS = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  output logic [7:0]        status_o,
  output logic              busy_o,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data
);
  localparam int OFF_W  = $clog2(PAGE);
  localparam int BASE_W = ADDR_W - OFF_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CNT_W  = $clog2(CYCLE_CLKS + PAGE + 1);

  wp_op_e op;
  logic   act;
  logic   wel, lock, locked, any_used, slot_used;
  logic [1:0]        prot;
  logic [BASE_W-1:0] page_base;
  logic [7:0]        slot_data;
  logic              wip_q;
  logic [CNT_W-1:0]  elapsed_q;
  logic              rd_valid_q;
  logic [7:0]        rd_data_q;
  logic [7:0]        mem_q [DEPTH];

  assign op        = wp_op_e'(cmd_op);
  assign cmd_ready = !(rd_valid_q && !rd_ready);
  assign act       = cmd_valid && cmd_ready && !wip_q;

  logic sr_ok, commit_go, cycle_end, drain_en;
  assign sr_ok     = act && (op == OP_WRSR) && wel && !(lock && !wp_n);
  assign commit_go = act && (op == OP_COMMIT) && wel && !locked && any_used;
  assign cycle_end = wip_q && (elapsed_q == CNT_W'(CYCLE_CLKS - 1));
  assign drain_en  = wip_q && (elapsed_q < CNT_W'(PAGE)) && slot_used;

  wp_status_reg u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_wel (act && (op == OP_WREN)),
    .clr_wel ((act && (op == OP_WRDI)) || sr_ok || (act && (op == OP_COMMIT))),
    .sr_load (sr_ok),
    .sr_lock (cmd_data[7]),
    .sr_prot (cmd_data[3:2]),
    .wel     (wel),
    .lock    (lock),
    .prot    (prot)
  );

  wp_page_buf #(.ADDR_W(ADDR_W), .PAGE(PAGE)) u_page (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_addr (act && (op == OP_LDADDR)),
    .addr_in   (cmd_addr),
    .push      (act && (op == OP_LDDATA)),
    .push_data (cmd_data),
    .clear     (cycle_end),
    .slot_sel  (elapsed_q[OFF_W-1:0]),
    .page_base (page_base),
    .any_used  (any_used),
    .slot_data (slot_data),
    .slot_used (slot_used)
  );

  wp_region u_region (
    .prot     (prot),
    .top_bits (page_base[BASE_W-1 -: 2]),
    .locked   (locked)
  );

  // Busy window: the first PAGE cycles drain one slot each into the array.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip_q     <= 1'b0;
      elapsed_q <= '0;
    end else if (commit_go) begin
      wip_q     <= 1'b1;
      elapsed_q <= '0;
    end else if (cycle_end) begin
      wip_q     <= 1'b0;
    end else if (wip_q) begin
      elapsed_q <= elapsed_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (drain_en) mem_q[{page_base, elapsed_q[OFF_W-1:0]}] <= slot_data;
    if (act && (op == OP_READ)) rd_data_q <= mem_q[cmd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rd_valid_q <= 1'b0;
    else if (act && (op == OP_READ)) rd_valid_q <= 1'b1;
    else if (rd_ready)               rd_valid_q <= 1'b0;
  end

  assign status_o = {lock, 3'b000, prot, wel, wip_q};
  assign busy_o   = wip_q;
  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
endmodule

// File: rtl/wp_eeprom_ctrl_chk.sv
`timescale 1ns/1ps
module wp_eeprom_ctrl_chk
  import wp_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int PAGE       = 32,
  parameter int CYCLE_CLKS = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wp_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [7:0]        cmd_data,
  input logic [7:0]        status_o,
  input logic              busy_o,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic act;
  assign act = cmd_valid && cmd_ready && !busy_o;

  logic [ADDR_W-1:0] last_addr;
  int                busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr <= '0;
      busy_len  <= 0;
    end else begin
      if (act && cmd_op == OP_LDADDR) last_addr <= cmd_addr;
      busy_len <= busy_o ? busy_len + 1 : 0;
    end
  end

  // Guard decision from address thresholds, apart from the design's decoder.
  logic guarded;
  always_comb begin
    case (status_o[3:2])
      2'b00:   guarded = 1'b0;
      2'b01:   guarded = int'(last_addr) >= (DEPTH * 3) / 4;
      2'b10:   guarded = int'(last_addr) >= DEPTH / 2;
      default: guarded = 1'b1;
    endcase
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> status_o[1:0] == 2'b00);
  p_wren_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act && cmd_op == OP_WREN |=> status_o[1]);
  p_wrsr_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act && cmd_op == OP_WRSR && status_o[1] && !(status_o[7] && !wp_n)
    |=> status_o[7] == $past(cmd_data[7]) && status_o[3:2] == $past(cmd_data[3:2]) && !status_o[1]);
  p_pin_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act && cmd_op == OP_WRSR && status_o[7] && !wp_n |=> $stable(status_o));
  p_busy_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(act && cmd_op == OP_COMMIT && status_o[1]));
  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> busy_len == CYCLE_CLKS);
  p_no_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    act && cmd_op == OP_COMMIT && !status_o[1] |=> !busy_o);
  p_guarded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    act && cmd_op == OP_COMMIT && guarded |=> !busy_o && !status_o[1]);
  p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(status_o[7:1]));
  p_busy_no_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !rd_valid |=> !rd_valid);
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));
  p_rd_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |-> !cmd_ready);
endmodule

bind wp_eeprom_ctrl wp_eeprom_ctrl_chk #(
  .ADDR_W(ADDR_W), .PAGE(PAGE), .CYCLE_CLKS(CYCLE_CLKS)
) i_chk (.*);

// File: tb/test_wp_eeprom_ctrl.sv
`timescale 1ns/1ps
module test_wp_eeprom_ctrl;
  import wp_pkg::*;
  localparam int AW = 13, PG = 32, CYC = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_n = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic rd_ready = 1'b1;
  logic cmd_ready, busy_o, rd_valid;
  logic [7:0] status_o, rd_data;

  always #2 clk = ~clk;  // 250 MHz

  wp_eeprom_ctrl #(.ADDR_W(AW), .PAGE(PG), .CYCLE_CLKS(CYC)) i_wp_eeprom_ctrl (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .status_o(status_o),
    .busy_o(busy_o), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data));

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit started = 1'b0;

  function automatic void chk(bit ok, string tag, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act_v, exp_v);
    end
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_mem [int];
  logic [7:0] m_buf [PG];
  bit         m_used [PG];
  int  m_base = 0, m_off = 0, m_cnt = 0;
  bit  m_wel = 0, m_wip = 0, m_lock = 0, m_rdv = 0, m_rdk = 0;
  bit [1:0] m_prot = 0;
  logic [7:0] m_rdd = 0;

  function automatic logic [7:0] m_status();
    return {m_lock, 3'b000, m_prot, m_wel, m_wip};
  endfunction

  function automatic bit m_guard(int base);
    case (m_prot)
      2'd0: return 1'b0;
      2'd1: return base >= 'h1800;
      2'd2: return base >= 'h1000;
      default: return 1'b1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit rdy, fire, any;
    if (!rst_n) begin
      m_wel = 0; m_wip = 0; m_cnt = 0; m_rdv = 0; m_off = 0; m_base = 0;
      foreach (m_used[i]) m_used[i] = 0;
    end else begin
      rdy  = !(m_rdv && !rd_ready);
      fire = cmd_valid && rdy;
      if (m_rdv && rd_ready) m_rdv = 0;
      if (m_wip) begin
        m_cnt++;
        if (m_cnt == CYC) begin
          foreach (m_used[i]) if (m_used[i]) m_mem[m_base + i] = m_buf[i];
          foreach (m_used[i]) m_used[i] = 0;
          m_wip = 0;
        end
      end else if (fire) begin
        case (cmd_op)
          OP_WREN: m_wel = 1;
          OP_WRDI: m_wel = 0;
          OP_WRSR: if (m_wel && !(m_lock && !wp_n)) begin
            m_lock = cmd_data[7]; m_prot = cmd_data[3:2]; m_wel = 0;
          end
          OP_LDADDR: begin
            m_base = int'(cmd_addr) & ~(PG - 1); m_off = int'(cmd_addr) % PG;
            foreach (m_used[i]) m_used[i] = 0;
          end
          OP_LDDATA: begin
            m_buf[m_off] = cmd_data; m_used[m_off] = 1; m_off = (m_off + 1) % PG;
          end
          OP_COMMIT: if (m_wel) begin
            m_wel = 0;
            any = 0;
            foreach (m_used[i]) any |= m_used[i];
            if (!m_guard(m_base) && any) begin m_wip = 1; m_cnt = 0; end
          end
          OP_READ: begin
            m_rdv = 1;
            m_rdk = m_mem.exists(int'(cmd_addr));
            m_rdd = m_rdk ? m_mem[int'(cmd_addr)] : 8'h00;
          end
          default: ;
        endcase
      end
    end
  end

  // Every-clock comparison, away from the active edge.
  always @(negedge clk) if (started) begin
    chk(status_o === m_status(), {cur_req, " status"}, status_o, m_status());
    chk(busy_o === m_wip, {cur_req, " busy"}, busy_o, m_wip);
    chk(rd_valid === m_rdv, {cur_req, " rd_valid"}, rd_valid, m_rdv);
    chk(cmd_ready === !(m_rdv && !rd_ready), {cur_req, " cmd_ready"}, cmd_ready, !(m_rdv && !rd_ready));
    if (m_rdv && m_rdk) chk(rd_data === m_rdd, {cur_req, " rd_data"}, rd_data, m_rdd);
  end

  // ---------------- stimulus ----------------
  task automatic cmd(input logic [2:0] op, input logic [12:0] a = '0, input logic [7:0] d = '0);
    @(negedge clk); #1;
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic expect_status(input logic [7:0] exp, input string tag);
    @(negedge clk);
    chk(status_o === exp, tag, status_o, exp);
  endtask

  task automatic read_expect(input logic [12:0] a, input logic [7:0] exp, input string tag);
    cmd(OP_READ, a);
    @(negedge clk);
    chk(rd_valid === 1'b1 && rd_data === exp, tag, rd_data, exp);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
  endtask

  task automatic write_byte(input logic [12:0] a, input logic [7:0] d);
    cmd(OP_WREN); cmd(OP_LDADDR, a); cmd(OP_LDDATA, '0, d); cmd(OP_COMMIT);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected done");
    checks++; errors++;
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    started = 1'b1;
    @(negedge clk); #1 rst_n = 1'b1;
    expect_status(8'h00, "R1");

    cur_req = "R2";
    cmd(OP_WREN); expect_status(8'h02, "R2");
    cmd(OP_WRDI); expect_status(8'h00, "R2");

    cur_req = "R3";
    cmd(OP_WRSR, '0, 8'h8C); expect_status(8'h00, "R3");
    cmd(OP_WREN); cmd(OP_WRSR, '0, 8'hFF); expect_status(8'h8C, "R3");

    cur_req = "R4";
    wp_n = 1'b0;
    cmd(OP_WREN); cmd(OP_WRSR, '0, 8'h00); expect_status(8'h8E, "R4");
    wp_n = 1'b1;
    cmd(OP_WRSR, '0, 8'h00); expect_status(8'h00, "R4");

    cur_req = "R1";
    cmd(OP_WREN); cmd(OP_WRSR, '0, 8'h04); cmd(OP_WREN); expect_status(8'h06, "R1");
    @(negedge clk); #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    expect_status(8'h04, "R1");

    cur_req = "R6";
    cmd(OP_WREN); cmd(OP_LDADDR, 13'h0105);
    cmd(OP_LDDATA, '0, 8'hA1); cmd(OP_LDDATA, '0, 8'hB2); cmd(OP_LDDATA, '0, 8'hC3);
    cmd(OP_COMMIT);
    n = 0;
    @(negedge clk);
    chk(status_o === 8'h05, "R6 start", status_o, 8'h05);
    while (busy_o) begin n++; @(negedge clk); end
    chk(n == CYC, "R6 length", n, CYC);
    chk(status_o === 8'h04, "R6 end", status_o, 8'h04);
    read_expect(13'h0105, 8'hA1, "R6");
    read_expect(13'h0107, 8'hC3, "R6");

    cur_req = "R5";
    cmd(OP_WREN); cmd(OP_LDADDR, 13'h021E);
    for (int i = 0; i < 34; i++) cmd(OP_LDDATA, '0, 8'h40 + 8'(i));
    cmd(OP_COMMIT);
    cur_req = "R9";
    cmd(OP_WREN); cmd(OP_WRSR, '0, 8'h00); cmd(OP_READ, 13'h0105);
    @(negedge clk);
    chk(rd_valid === 1'b0, "R9 read dropped", rd_valid, 0);
    cmd(OP_LDADDR, 13'h0000); cmd(OP_LDDATA, '0, 8'hEE);
    expect_status(8'h05, "R9");
    wait_idle();
    cur_req = "R5";
    read_expect(13'h021E, 8'h60, "R5");
    read_expect(13'h021F, 8'h61, "R5");
    read_expect(13'h0200, 8'h42, "R5");
    read_expect(13'h021D, 8'h5F, "R5");

    cur_req = "R8";
    cmd(OP_WREN); cmd(OP_WRSR, '0, 8'h00);
    write_byte(13'h1810, 8'h11); wait_idle();
    cmd(OP_WREN); cmd(OP_WRSR, '0, 8'h04);
    write_byte(13'h1810, 8'h77); expect_status(8'h04, "R8 guard 01");
    read_expect(13'h1810, 8'h11, "R8");
    write_byte(13'h17F0, 8'h22); expect_status(8'h05, "R8 open 01");
    wait_idle();
    read_expect(13'h17F0, 8'h22, "R8");
    cmd(OP_WREN); cmd(OP_WRSR, '0, 8'h08);
    write_byte(13'h1000, 8'h33); expect_status(8'h08, "R8 guard 10");
    write_byte(13'h0FE0, 8'h34); expect_status(8'h09, "R8 open 10");
    wait_idle();
    cmd(OP_WREN); cmd(OP_WRSR, '0, 8'h0C);
    write_byte(13'h0000, 8'h44); expect_status(8'h0C, "R8 guard 11");

    cur_req = "R7";
    cmd(OP_WREN); cmd(OP_WRSR, '0, 8'h00);
    cmd(OP_LDADDR, 13'h0300); cmd(OP_LDDATA, '0, 8'h55); cmd(OP_COMMIT);
    @(negedge clk);
    chk(busy_o === 1'b0 && status_o === 8'h00, "R7", status_o, 8'h00);

    cur_req = "R10";
    @(negedge clk); #1 rd_ready = 1'b0;
    cmd(OP_READ, 13'h0105);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(rd_valid === 1'b1 && rd_data === 8'hA1 && cmd_ready === 1'b0, "R10 hold", rd_data, 8'hA1);
    end
    #1 rd_ready = 1'b1;
    @(negedge clk);
    chk(rd_valid === 1'b0, "R10 taken", rd_valid, 0);
    cmd(OP_RDSR);
    expect_status(8'h00, "R10");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule